// File: doc/BRIEF.md
# Base/Limit Address Translator with Access Trap

This block sits between an address source (operand access or instruction fetch) and physical memory. A program sees its own region starting at address 0. Each access presents a program-relative address. The block adds a base register to that address to form the absolute address. It also checks the access against two limits: the size of physical memory and the size of the region. A legal access produces a grant with the absolute address. An illegal access produces a trap instead. Both results are registered and appear one cycle after the access strobe.

The base and the region size are loaded through one write port. That port has effect only while the processor-mode input indicates supervisor. A write made in user mode leaves both registers unchanged and raises a one-cycle privilege-fault pulse. Physical memory size is supplied on a port and is expected to stay constant. Reset selects an identity mapping: the base is 0 and the region size equals physical memory size.

Top module: `reloc_guard`

## Requirements
- R1: During reset the base register is cleared and the limit register is loaded from `mem_size`, so that afterwards an access at address a (with a < `mem_size`) is granted with `phys_addr` = a. While reset is held, all outputs are 0.
- R2: An access with `acc_valid`=1 whose checks both pass gives `acc_grant`=1, `acc_trap`=0 and `phys_addr` = base + `acc_vaddr` in the next cycle. A granted `phys_addr` is always below `mem_size`.
- R3: The sum base + `acc_vaddr` is formed one bit wider than the address. If this sum is at least `mem_size`, or its top (carry) bit is set, the access traps with `trap_cause`=1. This check has priority over the limit check.
- R4: If the physical check passes but `acc_vaddr` is at least the limit register, the access traps with `trap_cause`=0.
- R5: `acc_grant` and `acc_trap` are never high together. Exactly one of them is high in the cycle after each access. Neither is high after a cycle with `acc_valid`=0, and `trap_cause` is 0 whenever `acc_trap` is 0.
- R6: A write (`cfg_we`=1) with `sup_mode`=1 loads `cfg_base` and `cfg_limit`. An access in the same cycle as the write is still checked against the old values; accesses from the next cycle on use the new values.
- R7: A write with `sup_mode`=0 changes neither register and sets `priv_fault` for exactly the next cycle. `priv_fault` is 0 in every other case.
- R8: `phys_addr` is 0 in every cycle in which `acc_grant` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_size | input | AW+1 | Physical memory size q (constant) |
| sup_mode | input | 1 | 1 = supervisor, 0 = user |
| cfg_we | input | 1 | Write strobe for base and limit |
| cfg_base | input | AW | New base (absolute start of region) |
| cfg_limit | input | AW+1 | New region size |
| acc_valid | input | 1 | Access strobe |
| acc_vaddr | input | AW | Program-relative address |
| acc_grant | output | 1 | Access allowed (registered) |
| acc_trap | output | 1 | Memory trap (registered) |
| trap_cause | output | 1 | 1 = past physical memory, 0 = past region limit |
| phys_addr | output | AW | Absolute address on grant, else 0 |
| priv_fault | output | 1 | User-mode write attempted (registered) |

## Verification
If the base register is corrupted, every later grant shows a shifted `phys_addr`. Some accesses also move between grant and a physical-size trap, and this shows on the first access after the corruption. If the limit register is wrong, the grant/trap boundary at the region size shifts, so an access at limit-1 or at the limit shows the error one cycle after it is issued. A user write that leaks into the registers can only be seen through later accesses. For that reason the bench probes translation right after such writes, and random traffic keeps mixing writes in both modes with accesses.

// File: rtl/reloc_guard.sv
module reloc_guard #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW:0]   mem_size,
  input  logic          sup_mode,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_base,
  input  logic [AW:0]   cfg_limit,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_vaddr,
  output logic          acc_grant,
  output logic          acc_trap,
  output logic          trap_cause,
  output logic [AW-1:0] phys_addr,
  output logic          priv_fault
);

  logic [AW-1:0] base_q;
  logic [AW:0]   limit_q;

  wire [AW:0] sum       = {1'b0, base_q} + {1'b0, acc_vaddr};
  wire        over_phys = sum[AW] | (sum >= mem_size);
  wire        over_lim  = ({1'b0, acc_vaddr} >= limit_q);
  wire        bad       = over_phys | over_lim;
  wire        ok        = acc_valid & ~bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q     <= '0;
      limit_q    <= mem_size;
      acc_grant  <= 1'b0;
      acc_trap   <= 1'b0;
      trap_cause <= 1'b0;
      phys_addr  <= '0;
      priv_fault <= 1'b0;
    end else begin
      acc_grant  <= ok;
      acc_trap   <= acc_valid & bad;
      trap_cause <= acc_valid & over_phys;
      phys_addr  <= ok ? sum[AW-1:0] : '0;
      priv_fault <= cfg_we & ~sup_mode;
      if (cfg_we && sup_mode) begin
        base_q  <= cfg_base;
        limit_q <= cfg_limit;
      end
    end
  end

  assert_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_grant && acc_trap));
  assert_one_outcome_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> (acc_grant ^ acc_trap));
  assert_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> (!acc_grant && !acc_trap));
  assert_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trap_cause |-> acc_trap);
  assert_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_grant |-> ({1'b0, phys_addr} < mem_size));
  assert_user_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !sup_mode) |=> (priv_fault && $stable(base_q) && $stable(limit_q)));
  assert_no_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && !sup_mode) |=> !priv_fault);
  assert_zero_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_grant |-> (phys_addr == '0));

endmodule

// File: tb/reloc_guard_tb.sv
module reloc_guard_tb;
  localparam int AW = 8;
  localparam time CLK_PERIOD = 10ns;
  localparam int QSIZE = 200;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW:0]   mem_size = QSIZE[AW:0];
  logic          sup_mode = 1'b0;
  logic          cfg_we = 1'b0;
  logic [AW-1:0] cfg_base = '0;
  logic [AW:0]   cfg_limit = '0;
  logic          acc_valid = 1'b0;
  logic [AW-1:0] acc_vaddr = '0;
  logic          acc_grant, acc_trap, trap_cause, priv_fault;
  logic [AW-1:0] phys_addr;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  int m_base, m_limit;
  int e_grant, e_trap, e_cause, e_addr, e_fault;

  always #(CLK_PERIOD/2) clk = ~clk;

  reloc_guard #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .mem_size(mem_size), .sup_mode(sup_mode),
    .cfg_we(cfg_we), .cfg_base(cfg_base), .cfg_limit(cfg_limit),
    .acc_valid(acc_valid), .acc_vaddr(acc_vaddr), .acc_grant(acc_grant),
    .acc_trap(acc_trap), .trap_cause(trap_cause), .phys_addr(phys_addr),
    .priv_fault(priv_fault)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic int phys_over(input int b, input int a);
    int s;
    s = b + a;
    return ((s >= (1 << AW)) || (s >= QSIZE)) ? 1 : 0;
  endfunction

  // Drive one cycle, predict from the model, check after the edge, then update the model.
  task automatic cycle(input string tag, input bit v, input int a, input bit we,
                       input bit sup, input int nb, input int nl);
    int po, lo;
    acc_valid = v; acc_vaddr = a[AW-1:0];
    cfg_we = we; sup_mode = sup; cfg_base = nb[AW-1:0]; cfg_limit = nl[AW:0];
    po = phys_over(m_base, a);
    lo = (a >= m_limit) ? 1 : 0;
    e_grant = (v && !po && !lo) ? 1 : 0;
    e_trap  = (v && (po || lo)) ? 1 : 0;
    e_cause = (v && po) ? 1 : 0;
    e_addr  = e_grant ? (m_base + a) : 0;
    e_fault = (we && !sup) ? 1 : 0;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " grant"}, int'(acc_grant), e_grant);
    chk({tag, " trap"}, int'(acc_trap), e_trap);
    chk({tag, " cause"}, int'(trap_cause), e_cause);
    chk({tag, " addr"}, int'(phys_addr), e_addr);
    chk({tag, " fault"}, int'(priv_fault), e_fault);
    if (we && sup) begin
      m_base = nb; m_limit = nl;
    end
  endtask

  initial begin
    while (cycles < 200000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 200000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    m_base = 0; m_limit = QSIZE;
    repeat (3) @(negedge clk);
    // R1: outputs idle during reset
    chk("R1 reset grant", int'(acc_grant), 0);
    chk("R1 reset trap", int'(acc_trap), 0);
    chk("R1 reset addr", int'(phys_addr), 0);
    chk("R1 reset fault", int'(priv_fault), 0);
    rst_n = 1'b1;

    // R1: identity mapping after reset
    cycle("R1 identity", 1, 0, 0, 0, 0, 0);
    cycle("R1 identity top", 1, QSIZE-1, 0, 0, 0, 0);
    cycle("R3 at q", 1, QSIZE, 0, 0, 0, 0);
    cycle("R5 idle", 0, 5, 0, 0, 0, 0);

    // R6: supervisor write; same-cycle access uses old values
    cycle("R6 same cycle", 1, 60, 1, 1, 100, 50);
    cycle("R2 base 100", 1, 49, 0, 0, 0, 0);
    cycle("R4 at limit", 1, 50, 0, 0, 0, 0);
    cycle("R2 zero", 1, 0, 0, 0, 0, 0);

    // R7: user write ignored
    cycle("R7 user write", 1, 10, 1, 0, 7, 255);
    cycle("R7 after user write", 1, 49, 0, 0, 0, 0);
    cycle("R7 limit kept", 1, 50, 0, 0, 0, 0);

    // R3: physical overflow with priority over limit, and carry out
    cycle("R6 load", 0, 0, 1, 1, 180, 100);
    cycle("R3 over q", 1, 30, 0, 0, 0, 0);
    cycle("R3 priority", 1, 120, 0, 0, 0, 0);
    cycle("R2 edge", 1, 19, 0, 0, 0, 0);
    cycle("R6 load carry", 0, 0, 1, 1, 255, 256);
    cycle("R3 carry", 1, 255, 0, 0, 0, 0);
    cycle("R8 trap addr", 1, 1, 0, 0, 0, 0);

    // Random traffic (R2..R8)
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 3000; i++) begin
      bit v, we, sup;
      int a, nb, nl;
      v   = ($urandom % 4) != 0;
      we  = ($urandom % 8) == 0;
      sup = ($urandom % 3) != 0;
      a   = (($urandom % 2) == 0) ? int'($urandom % 256) : int'($urandom % 64);
      nb  = (($urandom % 2) == 0) ? int'($urandom % 256) : int'($urandom % 150);
      nl  = int'($urandom % 257);
      cycle("R2-rand", v, a, we, sup, nb, nl);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule